// File: doc/BRIEF.md
# Serial Audio Output Formatter

The block turns parallel stereo samples into a three-wire serial audio stream: a bit clock, a word clock and one data line. It runs from a master clock at 256 times the sample rate. It divides that clock by four to make a 64fs bit clock, so every frame holds a left slot and a right slot of 32 bit clocks each. Samples are up to 24 bits wide and come in through a valid/ready handshake with room for one pending stereo pair. Each pair is consumed at the start of a frame.

A 3-bit code picks the framing: MSB-first left-justified, I2S, MSB-first right-justified at 24, 20 or 16 bits, or LSB-first left-justified. The code is taken at the frame boundary, so a change never splits a frame. Three controls act at every bit boundary, in this order of priority:
- a hard mute;
- a pass-through that copies an external serial input to the data line;
- an optional mute that applies while the upstream clock recovery reports loss of lock.

Top module: `audio_serial_fmt`

## Requirements
- R1: While reset is held, the bit clock is high, the word clock and data are low, and sampleReady is high.
- R2: The bit clock is low for two master clocks and then high for two. A slot is 32 bit clocks and a frame is 64 bit clocks (256 master clocks). The left slot comes first.
- R3: The word clock changes only together with a falling bit-clock edge. It is high during the left slot, except under code 001, where it is low during the left slot.
- R4: A pair is accepted when sampleValid and sampleReady are both high. sampleReady is low while one pair is pending. The pending pair becomes the active pair at the next frame start. If nothing is pending then, the frame carries all-zero words.
- R5: Code 000 puts sample bits 23 down to 0 on slot bits 0 to 23. The remaining slot bits are zero.
- R6: Code 001 (I2S) sends a zero on slot bit 0, then sample bits 23 down to 0 on slot bits 1 to 24, then zeros.
- R7: Codes 010, 011 and 100 are right-justified with word lengths W of 24, 20 and 16. Slot bits 0 to 31-W are zero. The top W sample bits follow MSB first, so the LSB of the word is on slot bit 31.
- R8: Code 111 puts sample bits 0 up to 23 on slot bits 0 to 23, then zeros. Codes 101 and 110 drive the data line low.
- R9: The data line changes only together with a falling bit-clock edge, and it is stable for the whole bit.
- R10: While muteEn is high at a bit boundary, that bit is zero. The bit clock and the word clock keep running.
- R11: While passEn is high and muteEn is low at a bit boundary, that bit equals extIn sampled at the boundary. The locked input has no effect on this.
- R12: While unlockMuteEn is high, locked is low and both muteEn and passEn are low at a bit boundary, that bit is zero.
- R13: fmtSel is used only at frame starts. Changing it mid-frame alters neither the data nor the word clock until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256fs |
| rstN | input | 1 | Asynchronous active-low reset |
| leftIn | input | 24 | Left sample |
| rightIn | input | 24 | Right sample |
| sampleValid | input | 1 | Sample pair offered |
| sampleReady | output | 1 | Pending slot empty, pair can be taken |
| fmtSel | input | 3 | Framing code |
| muteEn | input | 1 | Force data low |
| passEn | input | 1 | Route extIn to the data line |
| unlockMuteEn | input | 1 | Mute while lock is lost |
| locked | input | 1 | Upstream lock indication |
| extIn | input | 1 | External serial data |
| bclkOut | output | 1 | Bit clock, 64fs |
| lrclkOut | output | 1 | Word clock, fs |
| dataOut | output | 1 | Serial data |

## Verification
The state that matters is the frame counter, the active sample pair and the latched framing code. A counter that is off by even one master clock shows up as a wrong bit-clock level within two cycles. It also puts a word-clock edge in the wrong place within one slot. A wrong active word, a skipped handshake or a misread code corrupts the very next bit of the data line, within four master clocks of the frame start. The sampleReady port shows it at once. A framing code taken mid-frame shows as a word-clock or data difference before the frame ends. The bench replays every master clock against its own model of the frame, so the first cycle that diverges is reported.

// File: rtl/audio_serial_fmt_pkg.sv
package audio_serial_fmt_pkg;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_I2S  = 3'd1,
    FMT_RJA  = 3'd2,
    FMT_RJB  = 3'd3,
    FMT_RJC  = 3'd4,
    FMT_RSV5 = 3'd5,
    FMT_RSV6 = 3'd6,
    FMT_LSBF = 3'd7
  } fmtCode_e;

  typedef struct packed {
    logic frameLoad;
    logic bitLoad;
    logic bclkNext;
    logic slotRight;
  } ctrlStrobes_t;

endpackage

// File: rtl/audio_serial_fmt_ctrl.sv
module audio_serial_fmt_ctrl
  import audio_serial_fmt_pkg::*;
#(
  parameter int CLK_PER_BIT = 4,
  parameter int SLOT_LEN    = 32,
  localparam int FRAME_CLKS = CLK_PER_BIT * SLOT_LEN * 2,
  localparam int CNT_W      = $clog2(FRAME_CLKS),
  localparam int PH_W       = $clog2(CLK_PER_BIT),
  localparam int POS_W      = $clog2(SLOT_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  output ctrlStrobes_t     strobes,
  output logic [POS_W-1:0] slotPos
);

  logic [CNT_W-1:0] frameCnt;
  logic [PH_W-1:0]  phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameCnt <= '0;
    else       frameCnt <= frameCnt + 1'b1;
  end

  assign phase = frameCnt[PH_W-1:0];
  assign slotPos = frameCnt[CNT_W-2:PH_W];

  always_comb begin
    strobes.frameLoad = (frameCnt == CNT_W'(FRAME_CLKS - 1));
    strobes.bitLoad   = (phase == '0);
    strobes.bclkNext  = (phase >= PH_W'(CLK_PER_BIT / 2));
    strobes.slotRight = frameCnt[CNT_W-1];
  end

endmodule

// File: rtl/audio_serial_fmt_datapath.sv
module audio_serial_fmt_datapath
  import audio_serial_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_LEN = 32,
  parameter int RJ_W_A   = 24,
  parameter int RJ_W_B   = 20,
  parameter int RJ_W_C   = 16,
  localparam int POS_W   = $clog2(SLOT_LEN),
  localparam int NUM_RJ  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [POS_W-1:0]    slotPos,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [2:0]          fmtSel,
  input  logic                muteEn,
  input  logic                passEn,
  input  logic                unlockMuteEn,
  input  logic                locked,
  input  logic                extIn,
  output logic                bclkOut,
  output logic                lrclkOut,
  output logic                dataOut
);

  localparam int RJ_WIDTHS [NUM_RJ] = '{RJ_W_A, RJ_W_B, RJ_W_C};

  logic [SAMPLE_W-1:0] pendLeft, pendRight, actLeft, actRight, curWord, revWord;
  logic                pendFull, accept;
  fmtCode_e            actFmt;
  logic [SLOT_LEN-1:0] ljImg, i2sImg, lsbImg, slotImg;
  logic [SLOT_LEN-1:0] rjImg [NUM_RJ];
  logic                fmtBit, nextBit, bclkQ, lrQ, dataQ;

  // One-deep holding slot; consumed at the frame boundary
  assign accept      = sampleValid && !pendFull;
  assign sampleReady = !pendFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFull  <= 1'b0;
      pendLeft  <= '0;
      pendRight <= '0;
      actLeft   <= '0;
      actRight  <= '0;
      actFmt    <= FMT_LJ;
    end else begin
      if (strobes.frameLoad) begin
        actFmt   <= fmtCode_e'(fmtSel);
        actLeft  <= pendFull ? pendLeft  : '0;
        actRight <= pendFull ? pendRight : '0;
      end
      if (accept) begin
        pendLeft  <= leftIn;
        pendRight <= rightIn;
        pendFull  <= 1'b1;
      end else if (strobes.frameLoad) begin
        pendFull <= 1'b0;
      end
    end
  end

  assign curWord = strobes.slotRight ? actRight : actLeft;

  // Slot images, bit SLOT_LEN-1 goes out first
  assign ljImg  = {curWord, {(SLOT_LEN - SAMPLE_W){1'b0}}};
  assign i2sImg = {1'b0, curWord, {(SLOT_LEN - SAMPLE_W - 1){1'b0}}};

  for (genvar b = 0; b < SAMPLE_W; b++) begin : g_rev
    assign revWord[b] = curWord[SAMPLE_W-1-b];
  end
  assign lsbImg = {revWord, {(SLOT_LEN - SAMPLE_W){1'b0}}};

  for (genvar k = 0; k < NUM_RJ; k++) begin : g_rj
    localparam int WLEN = RJ_WIDTHS[k];
    assign rjImg[k] = {{(SLOT_LEN - WLEN){1'b0}}, curWord[SAMPLE_W-1 -: WLEN]};
  end

  always_comb begin
    case (actFmt)
      FMT_LJ:   slotImg = ljImg;
      FMT_I2S:  slotImg = i2sImg;
      FMT_RJA:  slotImg = rjImg[0];
      FMT_RJB:  slotImg = rjImg[1];
      FMT_RJC:  slotImg = rjImg[2];
      FMT_LSBF: slotImg = lsbImg;
      default:  slotImg = '0;
    endcase
  end

  assign fmtBit = slotImg[POS_W'(SLOT_LEN - 1) - slotPos];

  always_comb begin
    if (muteEn)                       nextBit = 1'b0;
    else if (passEn)                  nextBit = extIn;
    else if (unlockMuteEn && !locked) nextBit = 1'b0;
    else                              nextBit = fmtBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ <= 1'b1;
      lrQ   <= 1'b0;
      dataQ <= 1'b0;
    end else begin
      bclkQ <= strobes.bclkNext;
      lrQ   <= (actFmt == FMT_I2S) ? strobes.slotRight : !strobes.slotRight;
      if (strobes.bitLoad) dataQ <= nextBit;
    end
  end

  assign bclkOut  = bclkQ;
  assign lrclkOut = lrQ;
  assign dataOut  = dataQ;

endmodule

// File: rtl/audio_serial_fmt.sv
module audio_serial_fmt
  import audio_serial_fmt_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_LEN    = 32,
  parameter int CLK_PER_BIT = 4,
  localparam int POS_W      = $clog2(SLOT_LEN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                sampleValid,
  output logic                sampleReady,
  input  logic [2:0]          fmtSel,
  input  logic                muteEn,
  input  logic                passEn,
  input  logic                unlockMuteEn,
  input  logic                locked,
  input  logic                extIn,
  output logic                bclkOut,
  output logic                lrclkOut,
  output logic                dataOut
);

  ctrlStrobes_t     strobes;
  logic [POS_W-1:0] slotPos;

  audio_serial_fmt_ctrl #(
    .CLK_PER_BIT(CLK_PER_BIT),
    .SLOT_LEN   (SLOT_LEN)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .slotPos(slotPos)
  );

  audio_serial_fmt_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_LEN(SLOT_LEN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .slotPos     (slotPos),
    .leftIn      (leftIn),
    .rightIn     (rightIn),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .fmtSel      (fmtSel),
    .muteEn      (muteEn),
    .passEn      (passEn),
    .unlockMuteEn(unlockMuteEn),
    .locked      (locked),
    .extIn       (extIn),
    .bclkOut     (bclkOut),
    .lrclkOut    (lrclkOut),
    .dataOut     (dataOut)
  );

endmodule

// File: rtl/audio_serial_fmt_chk.sv
module audio_serial_fmt_chk (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic sampleReady,
  input logic muteEn,
  input logic passEn,
  input logic unlockMuteEn,
  input logic locked,
  input logic extIn,
  input logic bclkOut,
  input logic lrclkOut,
  input logic dataOut
);

  assert_bclk_high_two_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bclkOut) |=> $stable(bclkOut));

  assert_bclk_low_two_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bclkOut) |=> $stable(bclkOut));

  assert_lr_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrclkOut) |-> $fell(bclkOut));

  assert_take_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> !sampleReady);

  assert_data_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $fell(bclkOut));

  assert_mute_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(bclkOut) && $past(muteEn)) |-> !dataOut);

  assert_pass_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(bclkOut) && !$past(muteEn) && $past(passEn)) |-> (dataOut == $past(extIn)));

  assert_unlock_mute_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(bclkOut) && !$past(muteEn) && !$past(passEn) && $past(unlockMuteEn)
     && !$past(locked)) |-> !dataOut);

endmodule

bind audio_serial_fmt audio_serial_fmt_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleReady (sampleReady),
  .muteEn      (muteEn),
  .passEn      (passEn),
  .unlockMuteEn(unlockMuteEn),
  .locked      (locked),
  .extIn       (extIn),
  .bclkOut     (bclkOut),
  .lrclkOut    (lrclkOut),
  .dataOut     (dataOut)
);

// File: tb/tb_audio_serial_fmt.sv
module tb_audio_serial_fmt;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic [2:0]  fmtSel = 3'd0;
  logic        muteEn = 1'b0, passEn = 1'b0, unlockMuteEn = 1'b0, locked = 1'b1;
  logic        extIn = 1'b0;
  logic        bclkOut, lrclkOut, dataOut;

  int checks = 0;
  int errors = 0;
  bit feedOn = 0;
  bit extRand = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  audio_serial_fmt dut (
    .clk(clk), .rstN(rstN), .leftIn(leftIn), .rightIn(rightIn),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .fmtSel(fmtSel),
    .muteEn(muteEn), .passEn(passEn), .unlockMuteEn(unlockMuteEn),
    .locked(locked), .extIn(extIn), .bclkOut(bclkOut), .lrclkOut(lrclkOut),
    .dataOut(dataOut)
  );

  // ---------------- reference model ----------------
  int          mc = 0;
  logic [23:0] actL = '0, actR = '0;
  logic [2:0]  actFmt = 3'd0;
  bit          actEmpty = 1;
  logic [23:0] qL[$];
  logic [23:0] qR[$];
  logic        expBclk = 1'b1, expLr = 1'b0, expData = 1'b0, expReady = 1'b1;
  string       expTag = "R1";
  bit          accepted = 0;

  function automatic logic refBit(logic [2:0] f, logic [23:0] w, int p);
    int wl;
    case (f)
      3'd0: return (p < 24) ? w[23 - p] : 1'b0;                 // R5
      3'd1: return (p >= 1 && p <= 24) ? w[24 - p] : 1'b0;      // R6
      3'd2, 3'd3, 3'd4: begin                                   // R7
        wl = (f == 3'd2) ? 24 : (f == 3'd3) ? 20 : 16;
        return (p >= 32 - wl) ? w[55 - wl - p] : 1'b0;
      end
      3'd7: return (p < 24) ? w[p] : 1'b0;                      // R8
      default: return 1'b0;                                     // R8 reserved
    endcase
  endfunction

  function automatic string fmtTag(logic [2:0] f);
    case (f)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2, 3'd3, 3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    int ph, bi, slot, p;
    bit readyNow;
    logic [23:0] w;
    if (!rstN) begin
      mc = 0; actL = '0; actR = '0; actFmt = 3'd0; actEmpty = 1;
      qL.delete(); qR.delete();
      expBclk = 1'b1; expLr = 1'b0; expData = 1'b0; expReady = 1'b1;
      expTag = "R1"; accepted = 0;
    end else begin
      ph = mc % 4;
      bi = mc / 4;
      slot = bi / 32;
      p = bi % 32;
      readyNow = (qL.size() == 0);
      w = (slot == 1) ? actR : actL;
      expBclk = (ph >= 2);
      expLr = (actFmt == 3'd1) ? (slot == 1) : (slot == 0);
      if (ph == 0) begin
        if (muteEn) begin
          expData = 1'b0; expTag = "R10 R9";
        end else if (passEn) begin
          expData = extIn; expTag = "R11 R9";
        end else if (unlockMuteEn && !locked) begin
          expData = 1'b0; expTag = "R12 R9";
        end else begin
          expData = refBit(actFmt, w, p);
          expTag = {fmtTag(actFmt), " R9 R13", actEmpty ? " R4" : ""};
        end
      end
      if (mc == 255) begin
        actFmt = fmtSel;
        if (qL.size() > 0) begin
          actL = qL.pop_front(); actR = qR.pop_front(); actEmpty = 0;
        end else begin
          actL = '0; actR = '0; actEmpty = 1;
        end
      end
      accepted = sampleValid && readyNow;
      if (accepted) begin
        qL.push_back(leftIn); qR.push_back(rightIn);
      end
      expReady = (qL.size() == 0);
      mc = (mc + 1) % 256;
    end
  end

  // ---------------- compare on every clock ----------------
  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      checkBit("R2 bclk", bclkOut, expBclk);
      checkBit("R3 R13 lrclk", lrclkOut, expLr);
      checkBit({expTag, " data"}, dataOut, expData);
      checkBit("R4 ready", sampleReady, expReady);
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk) begin
    if (feedOn) begin
      if (!sampleValid || accepted) begin
        sampleValid <= 1'b1;
        leftIn  <= 24'($urandom);
        rightIn <= 24'($urandom);
      end
    end else begin
      sampleValid <= 1'b0;
    end
    if (extRand) extIn <= 1'($urandom);
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    checkBit("R1 bclk reset", bclkOut, 1'b1);
    checkBit("R1 lrclk reset", lrclkOut, 1'b0);
    checkBit("R1 data reset", dataOut, 1'b0);
    checkBit("R1 ready reset", sampleReady, 1'b1);
    rstN = 1'b1;

    // R4/R5: the first frames are underruns, then left-justified data
    repeat (300) @(negedge clk);
    feedOn = 1;
    repeat (768) @(negedge clk);

    // R6/R7/R8/R13: each code applied mid-frame
    foreach (fmtSel[i]) begin end
    for (int f = 1; f < 8; f++) begin
      fmtSel = 3'(f);
      repeat (100 + f * 7) @(negedge clk);
      repeat (600) @(negedge clk);
    end

    // R4: underrun mid-stream
    fmtSel = 3'd0;
    feedOn = 0;
    repeat (700) @(negedge clk);
    feedOn = 1;
    repeat (400) @(negedge clk);

    // R10: mute with pass-through also requested
    extRand = 1;
    muteEn = 1'b1;
    repeat (200) @(negedge clk);
    passEn = 1'b1;
    repeat (200) @(negedge clk);
    muteEn = 1'b0;

    // R11: pass-through while unlocked and unlock-mute armed
    locked = 1'b0;
    unlockMuteEn = 1'b1;
    repeat (400) @(negedge clk);
    passEn = 1'b0;

    // R12: unlock mute, then lock regained
    fmtSel = 3'd1;
    repeat (400) @(negedge clk);
    locked = 1'b1;
    repeat (600) @(negedge clk);
    unlockMuteEn = 1'b0;
    extRand = 0;
    fmtSel = 3'd3;
    repeat (600) @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule